// File: doc/BRIEF.md
# UART Modem Flow Control and Loopback Router

This block is the modem-control slice of a UART. It sits between the external flow-control and serial pins and the UART serial core. It synchronizes the clear-to-send input and corrects it for the programmed pin polarity. It drives the request-to-send output from a manual control bit. It decides whether the transmitter may move its next word from the holding register into the shift register. It also reports a clear-to-send status bit and a sticky delta bit to the modem status register.

A loopback mode routes the serializer output straight into the receiver and keeps driving the transmit pin. In this mode the receive pin is ignored and the request-to-send pin is held at its idle level. The manual request-to-send bit then takes the place of the external clear-to-send: it drives the status bit, raises the delta bit when set, and turns the transmitter on or off. Baud generation and the serializer are outside this block.

Top module: `uart_modem_flow`

## Requirements
- R1: With `cfgPolHigh`=0 both flow-control pins are active-low (pin level 0 means asserted). With `cfgPolHigh`=1 both are active-high.
- R2: `ctsPin` passes through a two-stage synchronizer. Outside loopback, `ctsStat` shows the asserted state of the pin after the third rising clock edge following a pin change, and not before.
- R3: With `cfgAutoCts`=1, outside loopback, while `ctsStat`=0, `txLoadOk` stays 0 even when `txLoadReq`=1. While `ctsStat`=1, `txLoadOk` equals `txLoadReq` in the same cycle.
- R4: With `cfgAutoCts`=0, outside loopback, `txLoadOk` equals `txLoadReq` whatever the level of `ctsPin`.
- R5: With `cfgLoop`=1, `rxSerOut` equals `txSerIn` and `rxPin` has no effect. With `cfgLoop`=0, `rxSerOut` equals `rxPin`.
- R6: `txPin` equals `txSerIn` in every mode, loopback included. The load gate never alters `txPin`, so a word already being shifted out completes after flow control is withdrawn.
- R7: With `cfgLoop`=1, `rtsPin` sits at its deasserted level (1 when `cfgPolHigh`=0, 0 when `cfgPolHigh`=1), and `ctsPin` has no effect on `ctsStat` or `dctsStat`.
- R8: With `cfgLoop`=1, a write of 1 to the manual RTS bit (`mrtsWrEn`=1, `mrtsWrData`=1) sets `ctsStat` and `dctsStat` after that edge, and lets `txLoadOk` follow `txLoadReq` regardless of `cfgAutoCts`. A write of 0 clears `ctsStat` and holds `txLoadOk` at 0.
- R9: Outside loopback, `dctsStat` sets on the same edge that `ctsStat` changes. It stays set until a cycle with `dctsClr`=1. If a set and a clear fall on the same edge, the set wins.
- R10: After reset, the manual RTS bit is 0 (so `rtsPin` is deasserted), and `ctsStat` and `dctsStat` are 0.
- R11: Outside loopback, the manual RTS bit drives `rtsPin`: a written 1 asserts the pin and a written 0 deasserts it, at the polarity of R1, after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPolHigh | input | 1 | Flow-control pin polarity, 1 = active-high |
| cfgAutoCts | input | 1 | Gate transmit loads on clear-to-send |
| cfgLoop | input | 1 | Internal loopback enable |
| mrtsWrEn | input | 1 | Write strobe for the manual RTS bit |
| mrtsWrData | input | 1 | Value written to the manual RTS bit |
| dctsClr | input | 1 | Write-one-to-clear strobe for the delta bit |
| ctsPin | input | 1 | Clear-to-send pin (asynchronous) |
| rtsPin | output | 1 | Request-to-send pin |
| rxPin | input | 1 | Serial receive pin |
| txPin | output | 1 | Serial transmit pin |
| txSerIn | input | 1 | Serializer output bit |
| rxSerOut | output | 1 | Bit delivered to the deserializer |
| txLoadReq | input | 1 | Transmitter asks to load the next word |
| txLoadOk | output | 1 | Load from holding to shift register allowed |
| ctsStat | output | 1 | Clear-to-send status, asserted = 1 |
| dctsStat | output | 1 | Sticky clear-to-send change flag |

## Verification
A corrupted synchronizer or status register shows at `ctsStat` one edge too early or too late against the three-edge latency. It then shows at `txLoadOk` in the same cycle when automatic gating is on. A lost or stuck delta flag shows at `dctsStat` on the edge after the missed change or the missed clear. A wrong mode select shows at once at `rxSerOut`, `rtsPin` or `txLoadOk`, because the routing and the gate are combinational from the registered state.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  // Strobes from the control section to the datapath section.
  typedef struct packed {
    logic loopSel;    // route serializer output into the receiver
    logic rtsAssert;  // logical (polarity-free) request-to-send level
    logic loadGate;   // allow holding-to-shift transfers
  } flowStrb_t;

endpackage

// File: rtl/flow_datapath.sv
module flow_datapath
  import uart_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  flowStrb_t strb,
  input  logic      cfgPolHigh,
  input  logic      ctsPin,
  input  logic      rxPin,
  input  logic      txSerIn,
  input  logic      txLoadReq,
  output logic      ctsAct,
  output logic      rtsPin,
  output logic      txPin,
  output logic      rxSerOut,
  output logic      txLoadOk
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;

  // Metastability chain on the asynchronous clear-to-send pin.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= ctsPin;
        end
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // Polarity correction: active-low pins are inverted.
  always_comb begin
    ctsAct = cfgPolHigh ? syncQ[LAST] : ~syncQ[LAST];
    rtsPin = cfgPolHigh ? strb.rtsAssert : ~strb.rtsAssert;
  end

  // Serial routing and load gating.
  always_comb begin
    txPin    = txSerIn;
    rxSerOut = strb.loopSel ? txSerIn : rxPin;
    txLoadOk = txLoadReq & strb.loadGate;
  end

endmodule

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import uart_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgLoop,
  input  logic      cfgAutoCts,
  input  logic      mrtsWrEn,
  input  logic      mrtsWrData,
  input  logic      dctsClr,
  input  logic      ctsAct,
  output flowStrb_t strb,
  output logic      ctsStat,
  output logic      dctsStat
);

  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic              mrtsQ;
  logic              ctsStatQ;
  logic              dctsQ;
  logic              ctsActPrev;
  logic [WARM_W-1:0] warmCnt;
  logic              warmDone;
  logic              mrtsNext;
  logic              ctsStatNext;
  logic              dctsSet;

  assign warmDone = (warmCnt == WARM_W'(WARM_MAX));

  // Count edges until the synchronizer and history hold real pin data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warmCnt <= '0;
    else if (!warmDone) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    mrtsNext    = mrtsWrEn ? mrtsWrData : mrtsQ;
    ctsStatNext = cfgLoop ? mrtsNext : ctsAct;
    if (cfgLoop) dctsSet = mrtsWrEn & mrtsWrData;
    else         dctsSet = warmDone & (ctsAct != ctsActPrev);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrtsQ      <= 1'b0;
      ctsStatQ   <= 1'b0;
      dctsQ      <= 1'b0;
      ctsActPrev <= 1'b0;
    end else begin
      mrtsQ      <= mrtsNext;
      ctsStatQ   <= ctsStatNext;
      ctsActPrev <= ctsAct;
      if (dctsSet)      dctsQ <= 1'b1;
      else if (dctsClr) dctsQ <= 1'b0;
    end
  end

  always_comb begin
    strb.loopSel   = cfgLoop;
    strb.rtsAssert = mrtsQ & ~cfgLoop;
    if (cfgLoop)         strb.loadGate = mrtsQ;
    else if (cfgAutoCts) strb.loadGate = ctsStatQ;
    else                 strb.loadGate = 1'b1;
  end

  assign ctsStat  = ctsStatQ;
  assign dctsStat = dctsQ;

  // R9: the delta flag holds until software clears it.
  assert_dcts_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dctsQ && !dctsClr) |=> dctsQ);

  // R9: every status change outside loopback leaves the delta flag set.
  assert_dcts_on_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLoop && $past(!cfgLoop) && $past(!cfgLoop, 2) && $past(warmDone)
     && ctsStatQ != $past(ctsStatQ)) |-> dctsQ);

  // R8: a loopback write of 1 sets status and delta on the next edge.
  assert_loop_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoop && mrtsWrEn && mrtsWrData) |=> (ctsStatQ && dctsQ));

endmodule

// File: rtl/uart_modem_flow.sv
module uart_modem_flow
  import uart_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgPolHigh,
  input  logic cfgAutoCts,
  input  logic cfgLoop,
  input  logic mrtsWrEn,
  input  logic mrtsWrData,
  input  logic dctsClr,
  input  logic ctsPin,
  output logic rtsPin,
  input  logic rxPin,
  output logic txPin,
  input  logic txSerIn,
  output logic rxSerOut,
  input  logic txLoadReq,
  output logic txLoadOk,
  output logic ctsStat,
  output logic dctsStat
);

  flowStrb_t strb;
  logic      ctsAct;

  flow_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgLoop    (cfgLoop),
    .cfgAutoCts (cfgAutoCts),
    .mrtsWrEn   (mrtsWrEn),
    .mrtsWrData (mrtsWrData),
    .dctsClr    (dctsClr),
    .ctsAct     (ctsAct),
    .strb       (strb),
    .ctsStat    (ctsStat),
    .dctsStat   (dctsStat)
  );

  flow_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgPolHigh (cfgPolHigh),
    .ctsPin     (ctsPin),
    .rxPin      (rxPin),
    .txSerIn    (txSerIn),
    .txLoadReq  (txLoadReq),
    .ctsAct     (ctsAct),
    .rtsPin     (rtsPin),
    .txPin      (txPin),
    .rxSerOut   (rxSerOut),
    .txLoadOk   (txLoadOk)
  );

  // R3: a deasserted status blocks loads under automatic gating.
  assert_auto_block_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAutoCts && !cfgLoop && !ctsStat) |-> !txLoadOk);

  // R7: loopback parks the request-to-send pin at its idle level.
  assert_loop_rts_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoop |-> (rtsPin == !cfgPolHigh));

endmodule

// File: tb/uart_modem_flow_tb.sv
module uart_modem_flow_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgPolHigh = 1'b0, cfgAutoCts = 1'b0, cfgLoop = 1'b0;
  logic mrtsWrEn = 1'b0, mrtsWrData = 1'b0, dctsClr = 1'b0;
  logic ctsPin = 1'b1, rxPin = 1'b1, txSerIn = 1'b1, txLoadReq = 1'b0;
  logic rtsPin, txPin, rxSerOut, txLoadOk, ctsStat, dctsStat;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_modem_flow u_dut (
    .clk(clk), .rstN(rstN), .cfgPolHigh(cfgPolHigh), .cfgAutoCts(cfgAutoCts),
    .cfgLoop(cfgLoop), .mrtsWrEn(mrtsWrEn), .mrtsWrData(mrtsWrData),
    .dctsClr(dctsClr), .ctsPin(ctsPin), .rtsPin(rtsPin), .rxPin(rxPin),
    .txPin(txPin), .txSerIn(txSerIn), .rxSerOut(rxSerOut),
    .txLoadReq(txLoadReq), .txLoadOk(txLoadOk), .ctsStat(ctsStat),
    .dctsStat(dctsStat)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeMrts(input logic v);
    mrtsWrEn = 1'b1; mrtsWrData = v;
    step(1);
    mrtsWrEn = 1'b0;
  endtask

  task automatic clearDcts();
    dctsClr = 1'b1;
    step(1);
    dctsClr = 1'b0;
  endtask

  task automatic t_reset();
    check(rtsPin, 1'b1, "R10 rts idle after reset");
    check(ctsStat, 1'b0, "R10 ctsStat after reset");
    check(dctsStat, 1'b0, "R10 dctsStat after reset");
  endtask

  task automatic t_sync();
    ctsPin = 1'b0;  // assert (active-low)
    step(1); check(ctsStat, 1'b0, "R2 edge1 no change");
    step(1); check(ctsStat, 1'b0, "R2 edge2 no change");
    check(dctsStat, 1'b0, "R9 delta not early");
    step(1); check(ctsStat, 1'b1, "R2 edge3 asserted");
    check(dctsStat, 1'b1, "R9 delta with change");
    step(3); check(dctsStat, 1'b1, "R9 delta sticky");
    clearDcts(); check(dctsStat, 1'b0, "R9 w1c clears");
    // set and clear on the same edge: set wins
    ctsPin = 1'b1;
    step(2);
    dctsClr = 1'b1;
    step(1);
    dctsClr = 1'b0;
    check(ctsStat, 1'b0, "R2 deasserted after 3 edges");
    check(dctsStat, 1'b1, "R9 set beats clear");
    clearDcts();
  endtask

  task automatic t_polarity();
    cfgPolHigh = 1'b1; ctsPin = 1'b1;
    step(4); clearDcts();
    check(ctsStat, 1'b1, "R1 high pin asserted when active-high");
    check(rtsPin, 1'b0, "R1 rts idle low when active-high");
    writeMrts(1'b1);
    check(rtsPin, 1'b1, "R11 rts asserted high");
    cfgPolHigh = 1'b0; ctsPin = 1'b0;
    step(4); clearDcts();
    check(rtsPin, 1'b0, "R1 rts asserted low when active-low");
    check(ctsStat, 1'b1, "R1 low pin asserted when active-low");
    writeMrts(1'b0);
    check(rtsPin, 1'b1, "R11 rts deasserted");
  endtask

  task automatic t_autoCts();
    cfgAutoCts = 1'b1; ctsPin = 1'b1; txLoadReq = 1'b1;
    step(4); clearDcts();
    check(txLoadOk, 1'b0, "R3 blocked while cts deasserted");
    txLoadReq = 1'b0; #1;
    check(txLoadOk, 1'b0, "R3 no request no load");
    txLoadReq = 1'b1; ctsPin = 1'b0;
    step(2); check(txLoadOk, 1'b0, "R3 still blocked before sync");
    step(1); check(txLoadOk, 1'b1, "R3 allowed once asserted");
    // mid-frame withdrawal: serial data keeps flowing
    ctsPin = 1'b1;
    for (int i = 0; i < 6; i++) begin
      txSerIn = i[0];
      step(1);
      check(txPin, i[0], "R6 frame continues out txPin");
    end
    check(txLoadOk, 1'b0, "R3 next load blocked");
    clearDcts();
  endtask

  task automatic t_noAuto();
    cfgAutoCts = 1'b0; txLoadReq = 1'b1; ctsPin = 1'b1;
    step(4);
    check(txLoadOk, 1'b1, "R4 cts deasserted ignored");
    ctsPin = 1'b0; step(4);
    check(txLoadOk, 1'b1, "R4 cts asserted ignored");
    txLoadReq = 1'b0; #1;
    check(txLoadOk, 1'b0, "R4 follows request");
    rxPin = 1'b0; #1; check(rxSerOut, 1'b0, "R5 rx pin routed");
    rxPin = 1'b1; #1; check(rxSerOut, 1'b1, "R5 rx pin routed high");
    clearDcts();
  endtask

  task automatic t_loop();
    cfgLoop = 1'b1; cfgAutoCts = 1'b1; txLoadReq = 1'b1;
    step(1); clearDcts();
    check(rtsPin, 1'b1, "R7 rts idle in loop");
    writeMrts(1'b1);
    check(rtsPin, 1'b1, "R7 rts stays idle after write");
    check(ctsStat, 1'b1, "R8 write 1 sets cts");
    check(dctsStat, 1'b1, "R8 write 1 sets delta");
    check(txLoadOk, 1'b1, "R8 transmitter enabled");
    clearDcts();
    writeMrts(1'b0);
    check(ctsStat, 1'b0, "R8 write 0 clears cts");
    check(txLoadOk, 1'b0, "R8 transmitter disabled");
    cfgAutoCts = 1'b0; #1;
    check(txLoadOk, 1'b0, "R8 disabled regardless of auto");
    writeMrts(1'b1); clearDcts();
    for (int i = 0; i < 6; i++) begin
      ctsPin = ~ctsPin; step(1);
    end
    step(3);
    check(ctsStat, 1'b1, "R7 cts pin ignored status");
    check(dctsStat, 1'b0, "R7 cts pin ignored delta");
    rxPin = 1'b1; txSerIn = 1'b0; #1;
    check(rxSerOut, 1'b0, "R5 loopback feeds receiver low");
    check(txPin, 1'b0, "R6 tx pin active in loop low");
    rxPin = 1'b0; txSerIn = 1'b1; #1;
    check(rxSerOut, 1'b1, "R5 rx pin ignored in loop");
    check(txPin, 1'b1, "R6 tx pin active in loop high");
    cfgPolHigh = 1'b1; #1;
    check(rtsPin, 1'b0, "R7 idle level active-high");
    cfgPolHigh = 1'b0; cfgLoop = 1'b0;
    step(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(5);
    t_reset();
    t_sync();
    t_polarity();
    t_autoCts();
    t_noAuto();
    t_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule